// File: doc/BRIEF.md
# Solid Voxel Column Accumulator

This block turns a stream of surface crossings into solid voxel columns. A fragment names a column by its (x, y) address and carries a depth value. The depth is converted into a layer index, and the layer index into a prefix mask: that layer's bit and every bit below it are set. The mask is combined into the stored column word with a bitwise XOR. Between an odd crossing and the next even crossing of a closed surface, the column is therefore filled, and no scanline walk is needed. Surfaces that are not closed along the depth axis can leave stray bits. That is acceptable behaviour and is not treated as an error.

Each update is a read-modify-write of a column word. The write lands one cycle after the fragment is accepted. A fragment that reaches the same column in the very next cycle takes the new value from the pending write, so back-to-back hits are never lost. A clear command sweeps every column to zero, one column per cycle. The block holds its fragment ready low for the whole sweep, and reset starts the same sweep. A registered read port returns one column word per request.

Top module: `voxcol_accum`

## Requirements
- R1: After reset the block runs a clear sweep. `frag_ready` is low at the first cycle after reset release, it rises within COLUMNS+1 cycles, and from then on every column reads zero.
- R2: `frag_z` is a signed fixed-point depth with FRAC_W fraction bits, so one unit is 2^FRAC_W (16384 by default). The layer index is floor((z + one) * LAYERS / (2 * one)) for z in [-one, +one). With the defaults, z = 0 gives layer 16 and z = -8192 gives layer 8.
- R3: Any depth at or below -one gives layer 0. Any depth at or above +one gives layer LAYERS-1.
- R4: The mask for a crossing at layer L has bits 0 through L set and all higher bits clear.
- R5: An accepted fragment replaces its column word with the old word XOR the mask. Two crossings at layers a < b leave exactly bits a+1 through b set.
- R6: Fragments accepted on consecutive cycles, to the same column or to different ones, all take effect. No update is lost.
- R7: A one-cycle `clr_req` pulse while the block is idle drives `frag_ready` low for exactly COLUMNS cycles, starting one cycle after the pulse. After the sweep every column reads zero.
- R8: A read request with `rd_en` high returns the word for (`rd_x`, `rd_y`) on `rd_data` in the next cycle, and `rd_valid` is high in that cycle. Bit 0 is the lowest layer. Lane k is bits 8k+7 down to 8k, so lane 0 holds layers 0-7 and lane 3 holds layers 24-31.
- R9: Each (x, y) address has its own column word. An update to one column leaves every other column unchanged.
- R10: While `frag_ready` is low, `frag_valid` has no effect: no column is modified by a fragment presented during a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; starts a clear sweep |
| clr_req | input | 1 | One-cycle pulse that starts zeroing all columns |
| frag_valid | input | 1 | Fragment present |
| frag_ready | output | 1 | Fragment can be accepted (low during a clear) |
| frag_x | input | X_W | Column x address |
| frag_y | input | Y_W | Column y address |
| frag_z | input | Z_W | Signed fixed-point depth |
| rd_en | input | 1 | Read request |
| rd_x | input | X_W | Read column x address |
| rd_y | input | Y_W | Read column y address |
| rd_valid | output | 1 | `rd_data` holds the requested word |
| rd_data | output | LAYERS | Column word, bit 0 is the lowest layer |

## Verification
The bench builds the block with an 8 by 4 grid (X_W=3, Y_W=2), full 32-layer columns and the default 16-bit depth with 14 fraction bits. The short grid makes a clear sweep last 32 cycles. That lets the bench measure the exact length of the ready-low window and read back every column after each sweep, so a missed or extra address is exposed. The full layer count and depth format keep both clamp edges, the midpoint and the lane boundaries at their real values.

// File: rtl/voxcol_pkg.sv
// Shared definitions for the voxel column accumulator.
// Assumes: layer count is a power of two; the grid is a power of two per axis.
package voxcol_pkg;

    // Operating mode of the column store.
    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_CLEAR = 1'b1
    } store_mode_t;

    localparam int DEF_X_W    = 5;
    localparam int DEF_Y_W    = 5;
    localparam int DEF_LAYERS = 32;
    localparam int DEF_Z_W    = 16;
    localparam int DEF_FRAC_W = 14;

endpackage

// File: rtl/voxcol_depth_map.sv
// Maps a signed fixed-point depth in [-1, +1) onto a layer index.
// Assumes: LAYERS is a power of two and FRAC_W + 1 >= log2(LAYERS).
// Values at or below -1 clamp to layer 0, values at or above +1 clamp to the top layer.
module voxcol_depth_map #(
    parameter int Z_W    = 16,
    parameter int FRAC_W = 14,
    parameter int LAYERS = 32,
    localparam int L_W   = $clog2(LAYERS)
) (
    input  logic signed [Z_W-1:0] z,
    output logic        [L_W-1:0] layer
);
    localparam int BW    = Z_W + 2;
    localparam int SHIFT = FRAC_W + 1 - L_W;
    localparam int ONE   = 1 << FRAC_W;

    logic signed [BW-1:0] biased;
    logic        [BW-1:0] scaled;

    // Bias the depth to be non-negative, scale it to layers, then clamp.
    always_comb begin
        biased = BW'(z) + BW'(ONE);
        scaled = $unsigned(biased >>> SHIFT);
        if (biased <= 0) begin
            layer = '0;
        end else if (scaled >= BW'(LAYERS)) begin
            layer = L_W'(LAYERS - 1);
        end else begin
            layer = scaled[L_W-1:0];
        end
    end
endmodule

// File: rtl/voxcol_mask_gen.sv
// Builds the prefix mask for one crossing: the selected layer bit and all bits below it.
// Assumes: layer is always below LAYERS.
module voxcol_mask_gen #(
    parameter int LAYERS = 32,
    localparam int L_W   = $clog2(LAYERS)
) (
    input  logic [L_W-1:0]    layer,
    output logic [LAYERS-1:0] mask
);
    // One comparator per bit: bit i is set when i does not exceed the layer.
    for (genvar i = 0; i < LAYERS; i++) begin : g_bit
        assign mask[i] = (L_W'(i) <= layer);
    end
endmodule

// File: rtl/voxcol_store.sv
// Column word store with XOR read-modify-write, same-column forwarding,
// a sweeping clear and a registered read port.
// Assumes: upd_valid is only raised when busy is low. An update accepted in the
// same cycle as clr_req is erased by the sweep. A read issued in the cycle right
// after an update may return the word from before that update.
module voxcol_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    localparam int COLUMNS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_req,
    output logic              busy,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_mask,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    import voxcol_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(COLUMNS - 1);

    store_mode_t       mode_q;
    logic [ADDR_W-1:0] sweep_q;
    logic              s1_v;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_mask;
    logic [DATA_W-1:0] s1_old;
    logic [DATA_W-1:0] mem [COLUMNS];

    assign busy = (mode_q == ST_CLEAR);

    // Mode control: a sweep follows reset or a clear pulse and ends after the last column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= ST_CLEAR;
            sweep_q <= '0;
        end else if (mode_q == ST_CLEAR) begin
            if (sweep_q == LAST) begin
                mode_q <= ST_RUN;
            end
            sweep_q <= sweep_q + 1'b1;
        end else if (clr_req) begin
            mode_q  <= ST_CLEAR;
            sweep_q <= '0;
        end
    end

    // Update stage: capture the old word, forwarding a pending write to the same column.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
        end else begin
            s1_v <= upd_valid;
        end
        s1_addr <= upd_addr;
        s1_mask <= upd_mask;
        if (s1_v && (s1_addr == upd_addr)) begin
            s1_old <= s1_old ^ s1_mask;
        end else begin
            s1_old <= mem[upd_addr];
        end
    end

    // Single write port: the clear sweep wins over a pending update.
    always_ff @(posedge clk) begin
        if (rst_n && busy) begin
            mem[sweep_q] <= '0;
        end else if (rst_n && s1_v) begin
            mem[s1_addr] <= s1_old ^ s1_mask;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
        end
        rd_data <= mem[rd_addr];
    end

    AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sweep_q == LAST) |=> !busy); // R7
    AST_SWEEP_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && clr_req) |=> (busy && sweep_q == '0)); // R7
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R8
    AST_FORWARD_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && $past(s1_v) && !$past(busy) && s1_addr == $past(s1_addr))
        |-> (s1_old == ($past(s1_old) ^ $past(s1_mask)))); // R6
endmodule

// File: rtl/voxcol_accum.sv
// Top of the solid voxel column accumulator. It maps each fragment depth to a
// layer, builds the prefix mask and XORs it into the addressed column word.
// Assumes: column address is {y, x}. Ready is low during any clear sweep.
module voxcol_accum #(
    parameter int X_W    = voxcol_pkg::DEF_X_W,
    parameter int Y_W    = voxcol_pkg::DEF_Y_W,
    parameter int LAYERS = voxcol_pkg::DEF_LAYERS,
    parameter int Z_W    = voxcol_pkg::DEF_Z_W,
    parameter int FRAC_W = voxcol_pkg::DEF_FRAC_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr_req,
    input  logic                  frag_valid,
    output logic                  frag_ready,
    input  logic [X_W-1:0]        frag_x,
    input  logic [Y_W-1:0]        frag_y,
    input  logic signed [Z_W-1:0] frag_z,
    input  logic                  rd_en,
    input  logic [X_W-1:0]        rd_x,
    input  logic [Y_W-1:0]        rd_y,
    output logic                  rd_valid,
    output logic [LAYERS-1:0]     rd_data
);
    localparam int ADDR_W = X_W + Y_W;
    localparam int L_W    = $clog2(LAYERS);
    localparam int ONE    = 1 << FRAC_W;

    logic [L_W-1:0]    layer;
    logic [LAYERS-1:0] mask;
    logic              busy;
    logic              accept;

    assign frag_ready = !busy;
    assign accept     = frag_valid && frag_ready;

    voxcol_depth_map #(
        .Z_W    (Z_W),
        .FRAC_W (FRAC_W),
        .LAYERS (LAYERS)
    ) u_map (
        .z     (frag_z),
        .layer (layer)
    );

    voxcol_mask_gen #(
        .LAYERS (LAYERS)
    ) u_mask (
        .layer (layer),
        .mask  (mask)
    );

    voxcol_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (LAYERS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_req   (clr_req),
        .busy      (busy),
        .upd_valid (accept),
        .upd_addr  ({frag_y, frag_x}),
        .upd_mask  (mask),
        .rd_en     (rd_en),
        .rd_addr   ({rd_y, rd_x}),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && frag_z <= -ONE) |-> (layer == '0)); // R3
    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_valid && frag_z >= ONE) |-> (layer == L_W'(LAYERS - 1))); // R3
    AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        frag_valid |-> (mask[0] && ((mask & (mask + 1'b1)) == '0)
                        && $countones(mask) == int'(layer) + 1)); // R4
    AST_CLEAR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && frag_ready) |=> !frag_ready); // R10
endmodule

// File: tb/sim_voxcol_accum.sv
// Scoreboard bench: the stimulus tasks keep a shadow of every column, the read
// task queues the expected word, and a monitor compares each returned word.
module sim_voxcol_accum;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int X_W = 3;
    localparam int Y_W = 2;
    localparam int LAYERS = 32;
    localparam int Z_W = 16;
    localparam int FRAC_W = 14;
    localparam int COLS = 1 << (X_W + Y_W);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_req = 1'b0;
    logic frag_valid = 1'b0;
    logic frag_ready;
    logic [X_W-1:0] frag_x = '0;
    logic [Y_W-1:0] frag_y = '0;
    logic signed [Z_W-1:0] frag_z = '0;
    logic rd_en = 1'b0;
    logic [X_W-1:0] rd_x = '0;
    logic [Y_W-1:0] rd_y = '0;
    logic rd_valid;
    logic [LAYERS-1:0] rd_data;

    int checks = 0;
    int fails = 0;
    logic [LAYERS-1:0] model [COLS];
    logic [LAYERS-1:0] exp_q [$];
    string tag_q [$];

    always #4 clk = ~clk;

    voxcol_accum #(.X_W(X_W), .Y_W(Y_W), .LAYERS(LAYERS), .Z_W(Z_W), .FRAC_W(FRAC_W)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .frag_valid(frag_valid),
        .frag_ready(frag_ready), .frag_x(frag_x), .frag_y(frag_y), .frag_z(frag_z),
        .rd_en(rd_en), .rd_x(rd_x), .rd_y(rd_y), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic int layer_of(int z);
        int b = z + (1 << FRAC_W);
        int l;
        if (b <= 0) return 0;
        l = (b * LAYERS) / (2 << FRAC_W);
        return (l > LAYERS - 1) ? LAYERS - 1 : l;
    endfunction

    function automatic logic [LAYERS-1:0] mask_of(int z);
        logic [63:0] m = (64'd1 << (layer_of(z) + 1)) - 64'd1;
        return m[LAYERS-1:0];
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Called just after a negedge; returns just after the negedge following acceptance.
    task automatic send(int x, int y, int z);
        frag_valid = 1'b1;
        frag_x = X_W'(x);
        frag_y = Y_W'(y);
        frag_z = Z_W'(z);
        while (!frag_ready) @(negedge clk);
        @(negedge clk);
        model[y * (1 << X_W) + x] ^= mask_of(z);
    endtask

    task automatic idle();
        frag_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_col(int x, int y, string tag);
        rd_en = 1'b1;
        rd_x = X_W'(x);
        rd_y = Y_W'(y);
        exp_q.push_back(model[y * (1 << X_W) + x]);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_all(string tag);
        for (int a = 0; a < COLS; a++) read_col(a % (1 << X_W), a / (1 << X_W), tag);
        @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pop one expected word for every returned word.
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R8 actual=unexpected rd_valid expected=no data");
            end else begin
                check(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
            end
        end
    end

    task automatic run_all();
        int cnt;
        for (int a = 0; a < COLS; a++) model[a] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready low after reset", 64'(frag_ready), 64'd0);
        cnt = 0;
        while (!frag_ready && cnt < COLS + 4) begin cnt++; @(negedge clk); end
        check("R1 sweep ends in time", 64'(cnt <= COLS + 1), 64'd1);
        read_all("R1 column zero after reset");

        send(1, 1, 0); idle();
        read_col(1, 1, "R2 midpoint layer 16");
        read_col(2, 1, "R9 neighbour untouched");
        send(3, 2, -8192); idle();
        read_col(3, 2, "R2 quarter depth layer 8");
        send(3, 2, 8192); idle();
        read_col(3, 2, "R5 two crossings fill the slab");
        send(0, 0, -32768); idle();
        read_col(0, 0, "R3 clamp low");
        send(7, 3, 16384); idle();
        read_col(7, 3, "R3 at plus one is top layer");
        send(6, 3, 20000); idle();
        read_col(6, 3, "R3 above plus one is top layer");
        send(5, 0, -9216); idle();
        read_col(5, 0, "R8 lane 0 full, R4 prefix to layer 7");
        @(negedge clk); @(negedge clk);
        check("R8 lane one empty for layer 7", 64'(model[5][15:8]), 64'h0);

        send(4, 1, -16000); send(4, 1, 3000); send(4, 1, 15000); send(2, 2, 100); idle();
        read_col(4, 1, "R6 back-to-back same column");
        read_col(2, 2, "R6 back-to-back other column");
        read_all("R9 full grid after updates");

        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        frag_valid = 1'b1; frag_x = 3'd1; frag_y = 2'd2; frag_z = 16'sd0;
        cnt = 0;
        while (!frag_ready && cnt < COLS + 4) begin
            cnt++;
            if (cnt == COLS - 1) frag_valid = 1'b0;
            @(negedge clk);
        end
        frag_valid = 1'b0;
        check("R7 ready low for exactly COLUMNS cycles", 64'(cnt), 64'(COLS));
        for (int a = 0; a < COLS; a++) model[a] = '0;
        @(negedge clk);
        read_all("R7 R10 all zero after clear");
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(negedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule